// File: doc/BRIEF.md
# Host-Bus Control and Status Register Block

This block gives a host processor a small window of 32-bit registers on a plain synchronous bus. The bus has an address, a chip select, a read-not-write strobe, a write-data word and a read-data word. The window holds two registers. The identification register is fixed. It carries a two-byte version number that no host write can alter. The command register mixes three field behaviours in one word:

- a module-reset bit that the host can read and write, and which drives a reset level into user logic;
- a completion flag that mirrors a status input from user logic and cannot be written;
- a launch bit that the host can only write. Writing a 1 to it produces a single-clock pulse toward user logic, and it always reads back as 0.

Every field has its own reset value, and the block reset is synchronous and active low. A read returns data on the clock edge that samples the access, and that data stays on the read bus until the next read. An address that matches neither register reads as zero, and a write to it does nothing. An access takes place only while chip select is high.

Top module: `csr_regfile`

## Requirements
- R1: While rst_n is low at a clock edge, the block loads rdata with 0, mod_rst_o with 1 and start_o with 0. These values are visible after the first edge with rst_n low.
- R2: A read (cs=1, rnw=1) of byte address 0x000 returns 0x00000100 on rdata after the sampling edge. The low version byte (0) is in bits 7:0, the high version byte (1) is in bits 15:8, and bits 31:16 are zero.
- R3: A write (cs=1, rnw=0) to address 0x000 changes nothing, and later reads of 0x000 still return 0x00000100.
- R4: A write to address 0x100 loads bit 31 of wdata into the module-reset field. mod_rst_o shows the new value after the sampling edge, and a read of 0x100 returns that field in bit 31.
- R5: A read of 0x100 returns in bit 1 the value done_i had at the sampling edge. Writing bit 1 has no effect on it. The value read stays on rdata after done_i changes.
- R6: A write to 0x100 with wdata bit 0 set makes start_o high for exactly the one cycle after the sampling edge. start_o stays low at all other times, including during reads of 0x100. Bit 0 and all control bits other than 31 and 1 read back as 0.
- R7: Two writes of start=1 on consecutive cycles keep start_o high for two consecutive cycles. A new set wins over the self-clear.
- R8: A read of any address other than exactly 0x000 or 0x100 returns 0. A write to such an address leaves mod_rst_o unchanged and produces no start pulse.
- R9: While cs is low, no register changes and rdata holds its last value, whatever rnw, addr and wdata are. rdata also holds during writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 32 | Byte address of the access |
| cs | input | 1 | Chip select; an access occurs only while high |
| rnw | input | 1 | 1 selects read, 0 selects write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| done_i | input | 1 | Completion status from user logic |
| mod_rst_o | output | 1 | Module-reset level to user logic |
| start_o | output | 1 | One-cycle launch pulse to user logic |

## Verification
Two behaviours of the launch field can meet in the same cycle. The first is the self-clear, which would drop start_o after one cycle. The second is a new host write of 1 to bit 0, which would raise it again. The bench provokes this with two command-register writes of 0x80000001 on consecutive cycles. It requires start_o to be high after each of the two edges and low after the idle cycle that follows. A single write that also sets the module-reset bit checks that both fields of one word take effect on the same edge.

// File: rtl/csr_pkg.sv
// Package csr_pkg
// Shared constants and types for the control/status register block.
// Assumes a 32-bit data path and exact byte-address decode.
package csr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;

    // Register byte addresses.
    localparam logic [ADDR_W-1:0] ID_ADDR  = 32'h0000_0000;
    localparam logic [ADDR_W-1:0] CMD_ADDR = 32'h0000_0100;

    // Identification register layout: two constant bytes.
    localparam int ID_FIELDS   = 2;
    localparam int ID_FIELD_W  = 8;
    localparam logic [ID_FIELD_W-1:0] ID_MINOR = 8'd0; // bits 7:0
    localparam logic [ID_FIELD_W-1:0] ID_MAJOR = 8'd1; // bits 15:8

    // Command register bit positions.
    localparam int CMD_RST_BIT   = 31;
    localparam int CMD_DONE_BIT  = 1;
    localparam int CMD_START_BIT = 0;

    // Per-field reset values.
    localparam logic CMD_RST_INIT   = 1'b1;
    localparam logic CMD_START_INIT = 1'b0;

    // Access behaviour of a single field.
    typedef enum logic [1:0] {
        FM_RO_CONST = 2'd0,  // constant, host writes ignored
        FM_RO_LIVE  = 2'd1,  // follows an input from user logic
        FM_RW       = 2'd2,  // host read/write storage
        FM_WO_PULSE = 2'd3   // host write-only, clears after one cycle
    } field_mode_e;

    // Which register the current address selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ID   = 2'd1,
        SEL_CMD  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/csr_decode.sv
// Module csr_decode
// Turns the host access strobes into per-register write enables and a
// read select. Assumes one access per cycle and a full-width exact
// match on the byte address; any other address selects nothing.
module csr_decode
    import csr_pkg::*;
#(
    parameter int                ADDR_WIDTH = ADDR_W,
    parameter logic [ADDR_W-1:0] ID_BASE    = ID_ADDR,
    parameter logic [ADDR_W-1:0] CMD_BASE   = CMD_ADDR
) (
    input  logic [ADDR_WIDTH-1:0] addr,
    input  logic                  cs,
    input  logic                  rnw,
    output logic                  wr_id,
    output logic                  wr_cmd,
    output logic                  rd_en,
    output reg_sel_e              rd_sel
);

    reg_sel_e hit;

    // Address match to a register select.
    always_comb begin
        if (addr == ADDR_WIDTH'(ID_BASE))
            hit = SEL_ID;
        else if (addr == ADDR_WIDTH'(CMD_BASE))
            hit = SEL_CMD;
        else
            hit = SEL_NONE;
    end

    // Qualify the select with chip select and direction.
    always_comb begin
        wr_id  = cs && !rnw && (hit == SEL_ID);
        wr_cmd = cs && !rnw && (hit == SEL_CMD);
        rd_en  = cs && rnw;
        rd_sel = hit;
    end

endmodule

// File: rtl/csr_field.sv
// Module csr_field
// One register field whose access behaviour is chosen by MODE.
// q is the value presented to user logic, rd_val the value the host
// reads back. Assumes wr_en is already qualified by decode.
module csr_field
    import csr_pkg::*;
#(
    parameter int               WIDTH     = 1,
    parameter field_mode_e      MODE      = FM_RW,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] live_in,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] rd_val
);

    generate
        if (MODE == FM_RO_CONST) begin : g_const
            logic unused_const;
            assign unused_const = ^{clk, rst_n, wr_en, wr_data, live_in};
            assign q      = RESET_VAL;
            assign rd_val = RESET_VAL;
        end else if (MODE == FM_RO_LIVE) begin : g_live
            logic unused_live;
            assign unused_live = ^{clk, rst_n, wr_en, wr_data};
            assign q      = live_in;
            assign rd_val = live_in;
        end else if (MODE == FM_RW) begin : g_rw
            logic [WIDTH-1:0] store;
            logic unused_rw;
            assign unused_rw = ^live_in;
            // Hold host-written value; reload reset value on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    store <= RESET_VAL;
                else if (wr_en)
                    store <= wr_data;
            end
            assign q      = store;
            assign rd_val = store;
        end else begin : g_pulse
            logic [WIDTH-1:0] pulse;
            logic unused_pulse;
            assign unused_pulse = ^live_in;
            // Capture a write for one cycle, otherwise fall back to zero.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pulse <= RESET_VAL;
                else if (wr_en)
                    pulse <= wr_data;
                else
                    pulse <= '0;
            end
            assign q      = pulse;
            assign rd_val = '0;
        end
    endgenerate

endmodule

// File: rtl/csr_readback.sv
// Module csr_readback
// Registered read-data path. Picks the selected register word on a read
// access and holds it until the next read. Unselected addresses give 0.
module csr_readback
    import csr_pkg::*;
#(
    parameter int DATA_WIDTH = DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  reg_sel_e              rd_sel,
    input  logic [DATA_WIDTH-1:0] id_word,
    input  logic [DATA_WIDTH-1:0] cmd_word,
    output logic [DATA_WIDTH-1:0] rdata
);

    logic [DATA_WIDTH-1:0] pick;

    // Select the word addressed by the current read.
    always_comb begin
        unique case (rd_sel)
            SEL_ID:  pick = id_word;
            SEL_CMD: pick = cmd_word;
            default: pick = '0;
        endcase
    end

    // Register read data on a read access, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= pick;
    end

endmodule

// File: rtl/csr_regfile.sv
// Module csr_regfile
// Top of the control/status register block: an identification register
// of constant bytes and a command register with a read-write reset bit,
// a live completion flag and a self-clearing launch bit.
// Assumes a synchronous active-low reset and one host access per cycle.
module csr_regfile
    import csr_pkg::*;
#(
    parameter int                ADDR_WIDTH = ADDR_W,
    parameter int                DATA_WIDTH = DATA_W,
    parameter logic [ADDR_W-1:0] ID_BASE    = ID_ADDR,
    parameter logic [ADDR_W-1:0] CMD_BASE   = CMD_ADDR
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_WIDTH-1:0] addr,
    input  logic                  cs,
    input  logic                  rnw,
    input  logic [DATA_WIDTH-1:0] wdata,
    output logic [DATA_WIDTH-1:0] rdata,
    input  logic                  done_i,
    output logic                  mod_rst_o,
    output logic                  start_o
);

    localparam int ID_USED_W = ID_FIELDS * ID_FIELD_W;
    localparam logic [ID_USED_W-1:0] ID_INIT = {ID_MAJOR, ID_MINOR};

    logic     wr_id;
    logic     wr_cmd;
    logic     rd_en;
    reg_sel_e rd_sel;

    logic [DATA_WIDTH-1:0] id_word;
    logic [DATA_WIDTH-1:0] cmd_word;
    logic [ID_USED_W-1:0]  id_bits;

    logic rst_rd;
    logic done_rd;
    logic start_rd;
    logic done_q;

    csr_decode #(
        .ADDR_WIDTH (ADDR_WIDTH),
        .ID_BASE    (ID_BASE),
        .CMD_BASE   (CMD_BASE)
    ) u_decode (
        .addr   (addr),
        .cs     (cs),
        .rnw    (rnw),
        .wr_id  (wr_id),
        .wr_cmd (wr_cmd),
        .rd_en  (rd_en),
        .rd_sel (rd_sel)
    );

    // Identification bytes: one constant field per byte.
    generate
        for (genvar i = 0; i < ID_FIELDS; i++) begin : g_id
            logic [ID_FIELD_W-1:0] id_q;
            csr_field #(
                .WIDTH     (ID_FIELD_W),
                .MODE      (FM_RO_CONST),
                .RESET_VAL (ID_INIT[i*ID_FIELD_W +: ID_FIELD_W])
            ) u_id_byte (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wr_id),
                .wr_data (wdata[i*ID_FIELD_W +: ID_FIELD_W]),
                .live_in ('0),
                .q       (id_q),
                .rd_val  (id_bits[i*ID_FIELD_W +: ID_FIELD_W])
            );
        end
    endgenerate

    // Module-reset bit: host read/write.
    csr_field #(
        .WIDTH     (1),
        .MODE      (FM_RW),
        .RESET_VAL (CMD_RST_INIT)
    ) u_rst_field (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_cmd),
        .wr_data (wdata[CMD_RST_BIT]),
        .live_in (1'b0),
        .q       (mod_rst_o),
        .rd_val  (rst_rd)
    );

    // Completion flag: mirrors user logic, writes ignored.
    csr_field #(
        .WIDTH     (1),
        .MODE      (FM_RO_LIVE),
        .RESET_VAL (1'b0)
    ) u_done_field (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_cmd),
        .wr_data (wdata[CMD_DONE_BIT]),
        .live_in (done_i),
        .q       (done_q),
        .rd_val  (done_rd)
    );

    // Launch bit: write-only, self-clearing pulse.
    csr_field #(
        .WIDTH     (1),
        .MODE      (FM_WO_PULSE),
        .RESET_VAL (CMD_START_INIT)
    ) u_start_field (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_cmd),
        .wr_data (wdata[CMD_START_BIT]),
        .live_in (1'b0),
        .q       (start_o),
        .rd_val  (start_rd)
    );

    logic unused_top;
    assign unused_top = done_q;

    // Assemble the two register words with unused bits at zero.
    always_comb begin
        id_word                = '0;
        id_word[ID_USED_W-1:0] = id_bits;
        cmd_word                = '0;
        cmd_word[CMD_RST_BIT]   = rst_rd;
        cmd_word[CMD_DONE_BIT]  = done_rd;
        cmd_word[CMD_START_BIT] = start_rd;
    end

    csr_readback #(
        .DATA_WIDTH (DATA_WIDTH)
    ) u_readback (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel),
        .id_word  (id_word),
        .cmd_word (cmd_word),
        .rdata    (rdata)
    );

endmodule

// File: rtl/csr_regfile_chk.sv
// Module csr_regfile_chk
// Port-level properties of csr_regfile, attached by bind below.
module csr_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] addr,
    input logic        cs,
    input logic        rnw,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        done_i,
    input logic        mod_rst_o,
    input logic        start_o
);

    logic cmd_hit;
    logic id_hit;
    assign cmd_hit = (addr == 32'h0000_0100);
    assign id_hit  = (addr == 32'h0000_0000);

    logic unused_chk;
    assign unused_chk = done_i;

    // First cycle out of reset shows reset values.
    p_reset_values_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mod_rst_o && !start_o && rdata == 32'h0));

    // Identification read returns the version word.
    p_id_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rnw && id_hit) |=> (rdata == 32'h0000_0100));

    // Reset bit moves only on a command-register write.
    p_rst_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && !rnw && cmd_hit) |=> $stable(mod_rst_o));

    // Launch pulse only follows a launch write.
    p_start_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && !rnw && cmd_hit && wdata[0]) |=> !start_o);

    // Launch write always produces the pulse.
    p_start_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !rnw && cmd_hit && wdata[0]) |=> start_o);

    // Unmapped read returns zero.
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rnw && !id_hit && !cmd_hit) |=> (rdata == 32'h0));

    // Read data holds when no read takes place.
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rnw) |=> $stable(rdata));

endmodule

bind csr_regfile csr_regfile_chk u_csr_regfile_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .cs        (cs),
    .rnw       (rnw),
    .wdata     (wdata),
    .rdata     (rdata),
    .done_i    (done_i),
    .mod_rst_o (mod_rst_o),
    .start_o   (start_o)
);

// File: tb/csr_regfile_bench.sv
module csr_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        cs = 1'b0;
    logic        rnw = 1'b1;
    logic [31:0] wdata = '0;
    logic        done_i = 1'b0;
    logic [31:0] rdata;
    logic        mod_rst_o;
    logic        start_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    csr_regfile u_csr_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .cs        (cs),
        .rnw       (rnw),
        .wdata     (wdata),
        .rdata     (rdata),
        .done_i    (done_i),
        .mod_rst_o (mod_rst_o),
        .start_o   (start_o)
    );

    typedef struct packed {
        logic        cs;
        logic        rnw;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        done;
        logic [31:0] exp_rd;
        logic        exp_rst;
        logic        exp_st;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    // Each entry is applied at a falling edge and judged at the next one.
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 32'h000, 32'h0,        1'b0, 32'h0000_0100, 1'b1, 1'b0, 4'd2}, // R2
        '{1'b1, 1'b0, 32'h000, 32'hFFFF_FFFF, 1'b0, 32'h0000_0100, 1'b1, 1'b0, 4'd3}, // R3
        '{1'b1, 1'b1, 32'h000, 32'h0,        1'b0, 32'h0000_0100, 1'b1, 1'b0, 4'd3}, // R3
        '{1'b1, 1'b1, 32'h100, 32'h0,        1'b0, 32'h8000_0000, 1'b1, 1'b0, 4'd4}, // R4
        '{1'b1, 1'b1, 32'h100, 32'h0,        1'b1, 32'h8000_0002, 1'b1, 1'b0, 4'd5}, // R5
        '{1'b1, 1'b0, 32'h100, 32'h0000_0002, 1'b0, 32'h8000_0002, 1'b0, 1'b0, 4'd4}, // R4
        '{1'b1, 1'b1, 32'h100, 32'h0,        1'b0, 32'h0000_0000, 1'b0, 1'b0, 4'd5}, // R5
        '{1'b1, 1'b0, 32'h100, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 4'd6}, // R6
        '{1'b0, 1'b1, 32'h100, 32'h0,        1'b0, 32'h0000_0000, 1'b0, 1'b0, 4'd6}, // R6
        '{1'b1, 1'b1, 32'h100, 32'h0,        1'b1, 32'h0000_0002, 1'b0, 1'b0, 4'd6}, // R6
        '{1'b1, 1'b0, 32'h100, 32'h8000_0001, 1'b0, 32'h0000_0002, 1'b1, 1'b1, 4'd7}, // R7
        '{1'b1, 1'b0, 32'h100, 32'h8000_0001, 1'b0, 32'h0000_0002, 1'b1, 1'b1, 4'd7}, // R7
        '{1'b0, 1'b0, 32'h100, 32'h0,        1'b0, 32'h0000_0002, 1'b1, 1'b0, 4'd7}, // R7
        '{1'b1, 1'b1, 32'h000, 32'h0,        1'b0, 32'h0000_0100, 1'b1, 1'b0, 4'd2}, // R2
        '{1'b1, 1'b0, 32'h004, 32'h0000_0001, 1'b0, 32'h0000_0100, 1'b1, 1'b0, 4'd8}, // R8
        '{1'b1, 1'b1, 32'h104, 32'h0,        1'b0, 32'h0000_0000, 1'b1, 1'b0, 4'd8}, // R8
        '{1'b1, 1'b1, 32'h000, 32'h0,        1'b0, 32'h0000_0100, 1'b1, 1'b0, 4'd2}, // R2
        '{1'b1, 1'b1, 32'h1000_0100, 32'h0,  1'b1, 32'h0000_0000, 1'b1, 1'b0, 4'd8}, // R8
        '{1'b0, 1'b0, 32'h100, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 4'd9}, // R9
        '{1'b0, 1'b1, 32'h000, 32'h0,        1'b0, 32'h0000_0000, 1'b1, 1'b0, 4'd9}  // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic r, input logic [31:0] a,
                         input logic [31:0] d, input logic dn);
        cs = c; rnw = r; addr = a; wdata = d; done_i = dn;
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        // R1: values after reset
        check("R1 rdata", rdata, 32'h0);
        check("R1 mod_rst", {31'b0, mod_rst_o}, 32'h1);
        check("R1 start", {31'b0, start_o}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].cs, VECS[i].rnw, VECS[i].addr, VECS[i].wdata, VECS[i].done);
            @(negedge clk);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            check({tag, " rdata"}, rdata, VECS[i].exp_rd);
            check({tag, " mod_rst"}, {31'b0, mod_rst_o}, {31'b0, VECS[i].exp_rst});
            check({tag, " start"}, {31'b0, start_o}, {31'b0, VECS[i].exp_st});
        end

        // R5: read value held after done_i changes
        drive(1'b1, 1'b1, 32'h100, 32'h0, 1'b1);
        @(negedge clk);
        drive(1'b0, 1'b1, 32'h100, 32'h0, 1'b0);
        @(negedge clk);
        check("R5 hold", rdata, 32'h8000_0002);

        // R6: a read of the command register fires no pulse
        drive(1'b1, 1'b1, 32'h100, 32'h0000_0001, 1'b0);
        @(negedge clk);
        check("R6 read no pulse", {31'b0, start_o}, 32'h0);

        // R4 + R6: one write clears reset bit and fires launch together
        drive(1'b1, 1'b0, 32'h100, 32'h0000_0001, 1'b0);
        @(negedge clk);
        check("R4 same-word", {31'b0, mod_rst_o}, 32'h0);
        check("R6 same-word", {31'b0, start_o}, 32'h1);
        drive(1'b1, 1'b1, 32'h000, 32'h0, 1'b0);
        @(negedge clk);
        check("R6 self-clear", {31'b0, start_o}, 32'h0);

        // R1: reset mid-run restores field reset values
        drive(1'b0, 1'b1, 32'h0, 32'h0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rerun rdata", rdata, 32'h0);
        check("R1 rerun mod_rst", {31'b0, mod_rst_o}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule